// File: doc/BRIEF.md
# Dual-Clock Presettable Up/Down Counter

This block is a four-bit counter steered by two separate count clocks instead of one clock and a direction pin. A rising edge on the up clock adds one while the down clock rests high. A rising edge on the down clock subtracts one while the up clock rests high. A parameter picks the counting range: binary (0 to 15) or decimal (0 to 9). A clear input forces the count to zero, and an active-low load input copies four jam bits into the count. Both act on level, with no count clock involved.

Both count clocks are treated as slow signals. A free-running system clock samples them through synchronizers and finds their rising edges, so the whole block uses a single clock. Two active-low flags come out of the block. The carry flag drops while the up clock is low and the count sits at its top value. The borrow flag drops while the down clock is low and the count is zero. Wiring carry to the up clock and borrow to the down clock of a following stage builds a wider counter with no glue logic.

Top module: `updown_dual_counter`

## Requirements
- R1: A rising edge of `up_clk` while `dn_clk` is high increments `q` by one.
- R2: A rising edge of `dn_clk` while `up_clk` is high decrements `q` by one.
- R3: A count-clock rising edge taken while the other count clock is low leaves `q` unchanged.
- R4: While `clear` is high, `q` becomes 0 on the next system clock. This overrides load and counting.
- R5: While `load_n` is low and `clear` is low, `q` takes `jam` on the next system clock, and count edges have no effect.
- R6: Counting wraps. In binary mode (`BCD_MODE`=0) 15 goes up to 0 and 0 goes down to 15. In decimal mode (`BCD_MODE`=1) 9 goes up to 0 and 0 goes down to 9, and a legal count stays within 0..9.
- R7: In decimal mode a loaded illegal value of 10..14 counts up by one per edge, and 15 counts up to 0. Counting down from any nonzero value subtracts one.
- R8: `carry_n` is low exactly when the synchronized `up_clk` is low and `q` equals the top value (15 binary, 9 decimal). Otherwise it is high.
- R9: `borrow_n` is low exactly when the synchronized `dn_clk` is low and `q` is 0. Otherwise it is high.
- R10: While the synchronous system reset `rst` is high, `q` is 0 and both flags are high. Both count clocks are then taken as resting high.
- R11: When both count clocks rise on the same system clock cycle, `q` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high system reset |
| up_clk | input | 1 | Count-up clock, acts on its rising edge |
| dn_clk | input | 1 | Count-down clock, acts on its rising edge |
| clear | input | 1 | Active-high clear of the count |
| load_n | input | 1 | Active-low parallel load of `jam` |
| jam | input | 4 | Parallel load value |
| q | output | 4 | Current count |
| carry_n | output | 1 | Active-low terminal-count flag for counting up |
| borrow_n | output | 1 | Active-low zero flag for counting down |

## Verification
Each timing below counts from the first system clock edge that samples a change on the inputs.
- A count-clock rising edge changes `q` on the third edge: two edges pass through the synchronizer and one updates the count.
- `clear` and `load_n` act on the first edge.
- The flags follow the synchronized clock level, so a falling count clock shows on them on the second edge.

The bench reproduces these delays with a reference model. The model pushes each sampled count-clock level into a two-entry queue. It compares `q` and both flags against its own prediction at every falling edge of the system clock, once the outputs have settled. Count pulses are held for four system cycles per level so that every edge lands and settles before the next stimulus.

// File: rtl/updn_pkg.sv
package updn_pkg;

    localparam int CNT_W = 4;
    localparam int BIN_TOP = (1 << CNT_W) - 1;
    localparam int DEC_TOP = 9;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        OP_HOLD,
        OP_CLEAR,
        OP_LOAD,
        OP_INC,
        OP_DEC
    } cnt_op_e;

    typedef struct packed {
        logic lvl;
        logic rise;
    } clk_view_t;

    function automatic cnt_t top_value(input bit bcd);
        return bcd ? cnt_t'(DEC_TOP) : cnt_t'(BIN_TOP);
    endfunction

    function automatic cnt_t step_up(input cnt_t v, input bit bcd);
        if (bcd && (v == cnt_t'(DEC_TOP) || v == cnt_t'(BIN_TOP)))
            return '0;
        return v + cnt_t'(1);
    endfunction

    function automatic cnt_t step_dn(input cnt_t v, input bit bcd);
        if (v == '0)
            return top_value(bcd);
        return v - cnt_t'(1);
    endfunction

    function automatic cnt_op_e pick_op(input logic clr, input logic ld_n,
                                        input clk_view_t up, input clk_view_t dn);
        logic go_up, go_dn;
        go_up = up.rise & dn.lvl;
        go_dn = dn.rise & up.lvl;
        if (clr)
            return OP_CLEAR;
        if (!ld_n)
            return OP_LOAD;
        if (go_up && !go_dn)
            return OP_INC;
        if (go_dn && !go_up)
            return OP_DEC;
        return OP_HOLD;
    endfunction

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync
    import updn_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      raw,
    output clk_view_t view
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= raw;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], raw};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[LAST];
    end

    always_comb begin
        view.lvl  = chain[LAST];
        view.rise = chain[LAST] & ~prev;
    end

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
    import updn_pkg::*;
#(
    parameter bit BCD_MODE = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clear,
    input  logic      load_n,
    input  cnt_t      jam,
    input  clk_view_t up,
    input  clk_view_t dn,
    output cnt_t      q
);

    cnt_op_e op;

    always_comb op = pick_op(clear, load_n, up, dn);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            unique case (op)
                OP_CLEAR: q <= '0;
                OP_LOAD:  q <= jam;
                OP_INC:   q <= step_up(q, BCD_MODE);
                OP_DEC:   q <= step_dn(q, BCD_MODE);
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/updn_flag_gen.sv
module updn_flag_gen
    import updn_pkg::*;
#(
    parameter bit BCD_MODE = 1'b0
) (
    input  logic up_lvl,
    input  logic dn_lvl,
    input  cnt_t q,
    output logic carry_n,
    output logic borrow_n
);

    localparam cnt_t TOP = top_value(BCD_MODE);

    always_comb begin
        carry_n  = ~(~up_lvl & (q == TOP));
        borrow_n = ~(~dn_lvl & (q == '0));
    end

endmodule

// File: rtl/updown_dual_counter.sv
module updown_dual_counter
    import updn_pkg::*;
#(
    parameter bit BCD_MODE    = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       up_clk,
    input  logic       dn_clk,
    input  logic       clear,
    input  logic       load_n,
    input  logic [3:0] jam,
    output logic [3:0] q,
    output logic       carry_n,
    output logic       borrow_n
);

    localparam int N_CLK = 2;

    logic [N_CLK-1:0] raw_clk;
    clk_view_t        views [N_CLK];
    cnt_t             cnt;

    assign raw_clk = {dn_clk, up_clk};

    generate
        for (genvar g = 0; g < N_CLK; g++) begin : g_sync
            updn_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .raw  (raw_clk[g]),
                .view (views[g])
            );
        end
    endgenerate

    updn_count_core #(.BCD_MODE(BCD_MODE)) u_core (
        .clk    (clk),
        .rst    (rst),
        .clear  (clear),
        .load_n (load_n),
        .jam    (cnt_t'(jam)),
        .up     (views[0]),
        .dn     (views[1]),
        .q      (cnt)
    );

    updn_flag_gen #(.BCD_MODE(BCD_MODE)) u_flags (
        .up_lvl   (views[0].lvl),
        .dn_lvl   (views[1].lvl),
        .q        (cnt),
        .carry_n  (carry_n),
        .borrow_n (borrow_n)
    );

    assign q = cnt;

endmodule

// File: rtl/updn_checker.sv
module updn_checker #(
    parameter bit BCD_MODE = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       clear,
    input logic       load_n,
    input logic [3:0] jam,
    input logic [3:0] q,
    input logic       carry_n,
    input logic       borrow_n
);

    localparam logic [3:0] TOPV = BCD_MODE ? 4'd9 : 4'd15;

    // R10: reset state
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (q == 4'd0 && carry_n && borrow_n));

    // R4: clear wins
    p_clear_zero_r4: assert property (@(posedge clk) disable iff (rst)
        clear |=> q == 4'd0);

    // R5: load copies jam
    p_load_jam_r5: assert property (@(posedge clk) disable iff (rst)
        (!clear && !load_n) |=> q == $past(jam));

    // R1: counting moves by at most one step or wraps
    p_single_step_r1: assert property (@(posedge clk) disable iff (rst)
        (!clear && load_n) |=> ($stable(q) || q == 4'($past(q) + 4'd1) ||
                                q == 4'($past(q) - 4'd1) || q == 4'd0 || q == TOPV));

    // R8: carry only at top value
    p_carry_top_r8: assert property (@(posedge clk) disable iff (rst)
        !carry_n |-> q == TOPV);

    // R9: borrow only at zero
    p_borrow_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !borrow_n |-> q == 4'd0);

    generate
        if (BCD_MODE) begin : g_dec
            // R6: legal decimal counts stay legal
            p_dec_legal_r6: assert property (@(posedge clk) disable iff (rst)
                (q <= 4'd9 && !clear && load_n) |=> q <= 4'd9);
        end
    endgenerate

endmodule

bind updown_dual_counter updn_checker #(.BCD_MODE(BCD_MODE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .load_n   (load_n),
    .jam      (jam),
    .q        (q),
    .carry_n  (carry_n),
    .borrow_n (borrow_n)
);

// File: tb/updown_dual_counter_tb.sv
module updown_dual_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       up_clk = 1'b1;
    logic       dn_clk = 1'b1;
    logic       clear = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] jam = 4'd0;

    logic [3:0] q_b, q_d;
    logic       cy_b, cy_d, bo_b, bo_d;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R10";

    always #2 clk = ~clk;   // 250 MHz

    updown_dual_counter #(.BCD_MODE(1'b0)) u_dut (
        .clk(clk), .rst(rst), .up_clk(up_clk), .dn_clk(dn_clk),
        .clear(clear), .load_n(load_n), .jam(jam),
        .q(q_b), .carry_n(cy_b), .borrow_n(bo_b));

    updown_dual_counter #(.BCD_MODE(1'b1)) u_dut_bcd (
        .clk(clk), .rst(rst), .up_clk(up_clk), .dn_clk(dn_clk),
        .clear(clear), .load_n(load_n), .jam(jam),
        .q(q_d), .carry_n(cy_d), .borrow_n(bo_d));

    // reference model: index 0 binary, index 1 decimal
    bit ua [2] = '{1'b1, 1'b1};
    bit ub [2] = '{1'b1, 1'b1};
    bit da [2] = '{1'b1, 1'b1};
    bit db [2] = '{1'b1, 1'b1};
    bit pu [2] = '{1'b1, 1'b1};
    bit pd [2] = '{1'b1, 1'b1};
    int mcnt [2] = '{0, 0};
    int mtop [2] = '{15, 9};

    function automatic int m_up(int v, int i);
        if (i == 1 && (v == 9 || v == 15)) return 0;
        return (v + 1) % 16;
    endfunction

    function automatic int m_dn(int v, int i);
        if (v == 0) return mtop[i];
        return v - 1;
    endfunction

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit su, sd, gu, gd;
            su = ua[i];
            sd = da[i];
            gu = su && !pu[i] && sd;
            gd = sd && !pd[i] && su;
            if (rst) begin
                mcnt[i] = 0;
                ua[i] = 1'b1; ub[i] = 1'b1; da[i] = 1'b1; db[i] = 1'b1;
                pu[i] = 1'b1; pd[i] = 1'b1;
            end else begin
                if (clear)               mcnt[i] = 0;
                else if (!load_n)        mcnt[i] = int'(jam);
                else if (gu && !gd)      mcnt[i] = m_up(mcnt[i], i);
                else if (gd && !gu)      mcnt[i] = m_dn(mcnt[i], i);
                pu[i] = su; pd[i] = sd;
                ua[i] = ub[i]; ub[i] = up_clk;
                da[i] = db[i]; db[i] = dn_clk;
            end
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk(cur_req, "q_bin", int'(q_b), mcnt[0]);
            chk(cur_req, "q_dec", int'(q_d), mcnt[1]);
            chk("R8", "carry_bin", int'(cy_b), (!ua[0] && mcnt[0] == 15) ? 0 : 1);
            chk("R8", "carry_dec", int'(cy_d), (!ua[1] && mcnt[1] == 9) ? 0 : 1);
            chk("R9", "borrow_bin", int'(bo_b), (!da[0] && mcnt[0] == 0) ? 0 : 1);
            chk("R9", "borrow_dec", int'(bo_d), (!da[1] && mcnt[1] == 0) ? 0 : 1);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            finish_run();
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic up_pulse();
        up_clk = 1'b0; tick(4);
        up_clk = 1'b1; tick(4);
    endtask

    task automatic dn_pulse();
        dn_clk = 1'b0; tick(4);
        dn_clk = 1'b1; tick(4);
    endtask

    initial begin
        // R10: reset
        tick(3);
        chk("R10", "q_bin_reset", int'(q_b), 0);
        chk("R10", "carry_reset", int'(cy_b), 1);
        rst = 1'b0;
        tick(2);

        // R1: count up
        cur_req = "R1";
        repeat (5) up_pulse();
        chk("R1", "q_bin_after5", int'(q_b), 5);
        chk("R1", "q_dec_after5", int'(q_d), 5);

        // R2: count down
        cur_req = "R2";
        repeat (2) dn_pulse();
        chk("R2", "q_bin_after_dn", int'(q_b), 3);

        // R3: gated by the other clock being low
        cur_req = "R3";
        dn_clk = 1'b0; tick(4);
        repeat (2) up_pulse();
        chk("R3", "q_bin_gated", int'(q_b), 3);
        dn_clk = 1'b1; tick(4);
        up_clk = 1'b0; tick(4);
        dn_pulse();
        up_clk = 1'b1; tick(4);

        // R5: load with count edges ignored
        cur_req = "R5";
        jam = 4'd14; load_n = 1'b0; tick(2);
        up_pulse();
        chk("R5", "q_bin_loaded", int'(q_b), 14);
        load_n = 1'b1; tick(4);

        // R6 / R8: wrap at top and carry flag
        cur_req = "R6";
        repeat (2) up_pulse();
        chk("R6", "q_bin_wrap_up", int'(q_b), 0);
        dn_pulse();
        chk("R6", "q_bin_wrap_dn", int'(q_b), 15);
        chk("R6", "q_dec_wrap_dn", int'(q_d), 9);
        up_pulse();
        up_pulse();

        // R7: illegal decimal values
        cur_req = "R7";
        jam = 4'd10; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
        repeat (6) up_pulse();
        chk("R7", "q_dec_from10", int'(q_d), 0);
        jam = 4'd13; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
        repeat (2) dn_pulse();

        // R4: clear overrides load and counting
        cur_req = "R4";
        jam = 4'd7; load_n = 1'b0; clear = 1'b1;
        up_pulse();
        chk("R4", "q_bin_clear", int'(q_b), 0);
        clear = 1'b0; load_n = 1'b1; tick(2);
        dn_pulse();

        // R11: simultaneous rises hold
        cur_req = "R11";
        jam = 4'd4; load_n = 1'b0; tick(2); load_n = 1'b1; tick(2);
        up_clk = 1'b0; dn_clk = 1'b0; tick(4);
        up_clk = 1'b1; dn_clk = 1'b1; tick(6);
        chk("R11", "q_bin_both", int'(q_b), 4);

        // R6: long wrap run in both modes
        cur_req = "R6";
        repeat (20) up_pulse();
        repeat (20) dn_pulse();
        tick(4);
        finish_run();
    end

endmodule